// File: doc/BRIEF.md
# IDE PIO Strobe Timer

This block drives the read and write strobes of programmed-I/O cycles toward IDE drives on a local bus. A host programs one byte-wide timing register per channel through a small four-location register port. Each byte packs an active-time code and a recovery-time code. Both codes count down, so a larger code gives a shorter time, and both lengths are counted in bus clocks.

When a requester asks for a drive access, the block takes a snapshot of the selected channel's timing. It raises the read or write strobe for the decoded active length, then stays busy for the decoded recovery length, and then pulses a completion flag. Two channels are supported. A legacy single-channel mode uses a narrower active code, and its mapping from code to clocks depends on a bus-speed flag that the host can read back. Data buffering, DMA and the drive protocol belong to other blocks.

Top module: `ide_strobe_timer`

## Requirements
- R1: In wide mode (legacy_mode=0) the strobe stays high for 17 minus bits 3:0 of the channel's timing byte, in clocks (code 0 gives 17, code 15 gives 2).
- R2: In wide mode the recovery lasts 15 minus bits 7:4 of the timing byte, in clocks. Codes 13, 14 and 15 all give the 2-clock minimum.
- R3: In legacy mode the active length is 8 minus bits 2:0 when bus_slow=1, and 9 minus bits 2:0 when bus_slow=0. Bit 3 of the byte has no effect.
- R4: In legacy mode the recovery lasts 18 minus bits 7:4 when bus_slow=1 and 15 minus bits 7:4 when bus_slow=0. Code 15 with bus_slow=0 gives no recovery cycle at all.
- R5: The register map is as follows. Offset 0 holds the channel-0 timing byte and offset 2 the channel-1 timing byte. Offset 1 is a read-only status byte: bit 0 is bus_slow, bit 1 is legacy_mode, and the other bits are zero. Offset 3 is the control byte: only bit 0 is stored and read back, and the other bits read as zero. Reads are combinational. A write to offset 1 is ignored.
- R6: A request for channel 1 is dropped when control bit 0 is 1 or when legacy_mode is 1. A dropped request raises no strobe, does not set busy and gives no done pulse.
- R7: A request is accepted on a clock edge where acc_req is high and busy is low. The strobe goes high in the cycle after acceptance. It is rd_strobe when acc_wr=0 and wr_strobe when acc_wr=1, and strobe_chan shows the channel. Busy stays high through the strobe and the recovery. Done is high for exactly one cycle after the recovery, with busy low in that cycle.
- R8: A request raised while busy is high is held off with no strobe. It is accepted on the edge that ends the done cycle, so its strobe starts in the cycle after done.
- R9: A timing byte written during an access does not change that access. It applies from the next access onward.
- R10: After reset both timing bytes and the control byte are zero, and busy, done and both strobes are low. Reset is synchronous and active low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 2 | Register port offset |
| reg_wr | input | 1 | Register write enable |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| bus_slow | input | 1 | 1 when the bus runs at or below 33 MHz |
| legacy_mode | input | 1 | 1 selects single-channel legacy decoding |
| acc_req | input | 1 | Drive access request |
| acc_chan | input | 1 | Requested channel |
| acc_wr | input | 1 | 1 = write access, 0 = read access |
| rd_strobe | output | 1 | Read strobe |
| wr_strobe | output | 1 | Write strobe |
| strobe_chan | output | 1 | Channel of the current access |
| busy | output | 1 | Access in strobe or recovery phase |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench uses the default parameters: two channels and a 5-bit cycle counter. With these settings both timing bytes at offsets 0 and 2 exist, and every length up to the 18-clock legacy recovery fits the counter. The bench sweeps all sixteen values of each timing nibble through the wide mapping and through the legacy mapping at both speed flags. This covers the clamped wide recovery codes, the zero-length legacy recovery and the ignored bit 3. Secondary-channel gating is exercised both through the control bit and through legacy mode.

// File: rtl/pio_timing_pkg.sv
// Package: shared state encoding and field widths for the IDE PIO strobe timer.
// Assumes timing bytes are 8 bits with the active code low and recovery code high.
package pio_timing_pkg;
    localparam int TIMING_W = 8;

    typedef enum logic [1:0] {
        SEQ_IDLE    = 2'd0,
        SEQ_ACTIVE  = 2'd1,
        SEQ_RECOVER = 2'd2,
        SEQ_DONE    = 2'd3
    } seq_state_t;
endpackage

// File: rtl/pio_timing_decode.sv
// Module: maps a timing byte onto active and recovery lengths in clocks.
// Wide mode: active = 17 - code[3:0], recovery = 15 - code[7:4] clamped to 2.
// Legacy mode: active = 8 or 9 - code[2:0]; recovery = 18 or 15 - code[7:4],
// chosen by the bus-speed flag. Assumes CNT_W is wide enough for 18.
module pio_timing_decode
    import pio_timing_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic [TIMING_W-1:0] code,
    input  logic                legacy,
    input  logic                bus_slow,
    output logic [CNT_W-1:0]    act_clks,
    output logic [CNT_W-1:0]    rec_clks
);
    logic [5:0] a_wide, r_wide, a_leg, r_leg;

    // Purpose: compute both mappings and select the one in force.
    always_comb begin
        a_wide   = 6'd17 - {2'b00, code[3:0]};
        r_wide   = (code[7:4] >= 4'd13) ? 6'd2 : (6'd15 - {2'b00, code[7:4]});
        a_leg    = 6'd8 - {3'b000, code[2:0]} + (bus_slow ? 6'd0 : 6'd1);
        r_leg    = (bus_slow ? 6'd18 : 6'd15) - {2'b00, code[7:4]};
        act_clks = CNT_W'(legacy ? a_leg : a_wide);
        rec_clks = CNT_W'(legacy ? r_leg : r_wide);
    end
endmodule

// File: rtl/pio_timing_regs.sv
// Module: host register bank holding the per-channel timing bytes and control.
// Map: channel k timing at offset 2*k, read-only status at 1, control at 3.
// Assumes NUM_CH <= 2 so every timing byte fits the two-bit offset space.
module pio_timing_regs
    import pio_timing_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [ADDR_W-1:0]                reg_addr,
    input  logic                             reg_wr,
    input  logic [TIMING_W-1:0]              reg_wdata,
    output logic [TIMING_W-1:0]              reg_rdata,
    input  logic                             bus_slow,
    input  logic                             legacy_mode,
    output logic [NUM_CH-1:0][TIMING_W-1:0]  timing,
    output logic                             sec_dis
);
    localparam logic [ADDR_W-1:0] OFF_STATUS  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] OFF_CONTROL = ADDR_W'(3);

    for (genvar k = 0; k < NUM_CH; k++) begin : g_timing
        localparam logic [ADDR_W-1:0] OFF_TIMING = ADDR_W'(2 * k);

        // Purpose: hold channel k's timing byte, reloaded by a host write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                timing[k] <= '0;
            else if (reg_wr && reg_addr == OFF_TIMING)
                timing[k] <= reg_wdata;
        end

        // R5: a timing byte only changes when its own offset is written
        p_timing_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !(reg_wr && reg_addr == OFF_TIMING) |=> $stable(timing[k]));
    end

    // Purpose: hold the secondary-disable control bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sec_dis <= 1'b0;
        else if (reg_wr && reg_addr == OFF_CONTROL)
            sec_dis <= reg_wdata[0];
    end

    // Purpose: combinational read multiplexer over the four offsets.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == OFF_STATUS)
            reg_rdata = {6'b0, legacy_mode, bus_slow};
        else if (reg_addr == OFF_CONTROL)
            reg_rdata = {7'b0, sec_dis};
        else
            for (int k = 0; k < NUM_CH; k++)
                if (reg_addr == ADDR_W'(2 * k))
                    reg_rdata = timing[k];
    end
endmodule

// File: rtl/pio_cycle_seq.sv
// Module: one-access-at-a-time strobe sequencer.
// On start it snapshots the lengths, runs the strobe phase, then the recovery
// phase, then a one-cycle done state in which a new start may be taken.
// Assumes act_clks >= 1 whenever start is high.
module pio_cycle_seq
    import pio_timing_pkg::*;
#(
    parameter int CNT_W = 5,
    parameter int CH_W  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CH_W-1:0]  start_chan,
    input  logic             start_wr,
    input  logic [CNT_W-1:0] act_clks,
    input  logic [CNT_W-1:0] rec_clks,
    output logic             ready,
    output logic             rd_strobe,
    output logic             wr_strobe,
    output logic [CH_W-1:0]  strobe_chan,
    output logic             busy,
    output logic             done
);
    seq_state_t       state;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] rec_q;
    logic             wr_q;

    // Purpose: advance the phase and count down the current phase length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= SEQ_IDLE;
            cnt         <= '0;
            rec_q       <= '0;
            wr_q        <= 1'b0;
            strobe_chan <= '0;
        end else begin
            case (state)
                SEQ_IDLE, SEQ_DONE: begin
                    if (start) begin
                        state       <= SEQ_ACTIVE;
                        cnt         <= act_clks - CNT_W'(1);
                        rec_q       <= rec_clks;
                        wr_q        <= start_wr;
                        strobe_chan <= start_chan;
                    end else begin
                        state <= SEQ_IDLE;
                    end
                end
                SEQ_ACTIVE: begin
                    if (cnt != '0) begin
                        cnt <= cnt - CNT_W'(1);
                    end else if (rec_q == '0) begin
                        state <= SEQ_DONE;
                    end else begin
                        state <= SEQ_RECOVER;
                        cnt   <= rec_q - CNT_W'(1);
                    end
                end
                default: begin
                    if (cnt != '0)
                        cnt <= cnt - CNT_W'(1);
                    else
                        state <= SEQ_DONE;
                end
            endcase
        end
    end

    // Purpose: decode phase outputs from the state.
    always_comb begin
        ready     = (state == SEQ_IDLE) || (state == SEQ_DONE);
        busy      = (state == SEQ_ACTIVE) || (state == SEQ_RECOVER);
        done      = (state == SEQ_DONE);
        rd_strobe = (state == SEQ_ACTIVE) && !wr_q;
        wr_strobe = (state == SEQ_ACTIVE) && wr_q;
    end

    // R1: every accepted access carries an active length in the legal range
    p_act_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (act_clks >= CNT_W'(1) && act_clks <= CNT_W'(17)));
    // R4: recovery length never exceeds the longest legacy value
    p_rec_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (rec_clks <= CNT_W'(18)));
    // R7: done only ever follows a busy cycle
    p_done_after_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));
    // R7: the strobe phase ends before done appears
    p_done_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(rd_strobe || wr_strobe));
endmodule

// File: rtl/ide_strobe_timer.sv
// Module: top of the IDE PIO strobe timer.
// Joins the register bank, the timing decoder and the sequencer. It gates
// requests to channels other than 0 when secondary access is disabled or
// legacy mode is on. Assumes requesters hold acc_req until it is accepted.
module ide_strobe_timer
    import pio_timing_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int CNT_W  = 5,
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          reg_addr,
    input  logic                reg_wr,
    input  logic [TIMING_W-1:0] reg_wdata,
    output logic [TIMING_W-1:0] reg_rdata,
    input  logic                bus_slow,
    input  logic                legacy_mode,
    input  logic                acc_req,
    input  logic [CH_W-1:0]     acc_chan,
    input  logic                acc_wr,
    output logic                rd_strobe,
    output logic                wr_strobe,
    output logic [CH_W-1:0]     strobe_chan,
    output logic                busy,
    output logic                done
);
    logic [NUM_CH-1:0][TIMING_W-1:0] timing;
    logic                            sec_dis;
    logic [TIMING_W-1:0]             sel_code;
    logic [CNT_W-1:0]                act_clks, rec_clks;
    logic                            chan_ok, ready, start;

    pio_timing_regs #(.NUM_CH(NUM_CH), .ADDR_W(2)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_addr   (reg_addr),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .bus_slow   (bus_slow),
        .legacy_mode(legacy_mode),
        .timing     (timing),
        .sec_dis    (sec_dis)
    );

    // Purpose: choose the requested channel's byte and decide if it may run.
    always_comb begin
        sel_code = timing[0];
        for (int k = 1; k < NUM_CH; k++)
            if (acc_chan == CH_W'(k))
                sel_code = timing[k];
        chan_ok = (acc_chan == '0) ||
                  (!sec_dis && !legacy_mode && (int'(acc_chan) < NUM_CH));
        start   = acc_req && ready && chan_ok;
    end

    pio_timing_decode #(.CNT_W(CNT_W)) u_decode (
        .code    (sel_code),
        .legacy  (legacy_mode),
        .bus_slow(bus_slow),
        .act_clks(act_clks),
        .rec_clks(rec_clks)
    );

    pio_cycle_seq #(.CNT_W(CNT_W), .CH_W(CH_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_chan (acc_chan),
        .start_wr   (acc_wr),
        .act_clks   (act_clks),
        .rec_clks   (rec_clks),
        .ready      (ready),
        .rd_strobe  (rd_strobe),
        .wr_strobe  (wr_strobe),
        .strobe_chan(strobe_chan),
        .busy       (busy),
        .done       (done)
    );

    // R6: a gated secondary request never starts an access
    p_sec_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && acc_chan != '0 && (sec_dis || legacy_mode) && !busy) |=> !busy);
    // R7: an access only begins after a request
    p_start_needs_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(acc_req));
    // R8: a new strobe never rises straight out of a busy cycle
    p_holdoff_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_strobe || wr_strobe) |-> !$past(busy));
endmodule

// File: tb/test_ide_strobe_timer.sv
// Bench: directed scenarios for the IDE PIO strobe timer, one task each.
module test_ide_strobe_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       bus_slow = 1'b1;
    logic       legacy_mode = 1'b0;
    logic       acc_req = 1'b0;
    logic       acc_chan = 1'b0;
    logic       acc_wr = 1'b0;
    logic       rd_strobe, wr_strobe, strobe_chan, busy, done;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    ide_strobe_timer i_ide_strobe_timer (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_slow(bus_slow),
        .legacy_mode(legacy_mode), .acc_req(acc_req), .acc_chan(acc_chan),
        .acc_wr(acc_wr), .rd_strobe(rd_strobe), .wr_strobe(wr_strobe),
        .strobe_chan(strobe_chan), .busy(busy), .done(done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_act(input bit leg, input bit slow, input logic [7:0] t);
        if (leg) return 8 - int'(t[2:0]) + (slow ? 0 : 1);
        return 17 - int'(t[3:0]);
    endfunction

    function automatic int exp_rec(input bit leg, input bit slow, input logic [7:0] t);
        int v;
        if (leg) return (slow ? 18 : 15) - int'(t[7:4]);
        v = 15 - int'(t[7:4]);
        return (v < 2) ? 2 : v;
    endfunction

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // Issue one access and measure strobe cycles, recovery cycles and done.
    task automatic do_access(input bit ch, input bit wr, output int a, output int r,
                             output bit kind_ok, output bit done_seen);
        @(negedge clk);
        acc_req = 1'b1; acc_chan = ch; acc_wr = wr;
        @(negedge clk);
        acc_req = 1'b0;
        a = 0; r = 0; kind_ok = 1'b1; done_seen = 1'b0;
        for (int i = 0; i < 60 && !done_seen; i++) begin
            if (done) begin
                done_seen = 1'b1;
                if (busy) kind_ok = 1'b0;
            end else if (rd_strobe || wr_strobe) begin
                a++;
                if (rd_strobe != !wr || wr_strobe != wr || strobe_chan != ch) kind_ok = 1'b0;
            end else if (busy) begin
                r++;
            end
            if (!done_seen) @(negedge clk);
        end
    endtask

    task automatic t_reset();
        logic [7:0] d;
        int a, r; bit k, ds;
        check(!busy && !done && !rd_strobe && !wr_strobe, "R10 outputs idle", busy, 0);
        reg_read(2'd0, d); check(d == 8'h00, "R10 timing0 reset", d, 0);
        reg_read(2'd2, d); check(d == 8'h00, "R10 timing1 reset", d, 0);
        reg_read(2'd3, d); check(d == 8'h00, "R10 control reset", d, 0);
        do_access(1'b0, 1'b0, a, r, k, ds);
        check(a == 17, "R10 slowest active", a, 17);
        check(r == 15, "R10 slowest recovery", r, 15);
        check(k && ds, "R7 done pulse after reset access", k, 1);
        @(negedge clk);
        check(!done, "R7 done lasts one cycle", done, 0);
    endtask

    task automatic t_regmap();
        logic [7:0] d;
        reg_write(2'd0, 8'hA5); reg_write(2'd2, 8'h3C);
        reg_read(2'd0, d); check(d == 8'hA5, "R5 timing0 readback", d, 8'hA5);
        reg_read(2'd2, d); check(d == 8'h3C, "R5 timing1 readback", d, 8'h3C);
        bus_slow = 1'b1; legacy_mode = 1'b0;
        reg_read(2'd1, d); check(d == 8'h01, "R5 status slow", d, 1);
        bus_slow = 1'b0; legacy_mode = 1'b1;
        reg_read(2'd1, d); check(d == 8'h02, "R5 status legacy fast", d, 2);
        reg_write(2'd1, 8'hFF);
        reg_read(2'd1, d); check(d == 8'h02, "R5 status write ignored", d, 2);
        reg_read(2'd0, d); check(d == 8'hA5, "R5 timing0 untouched", d, 8'hA5);
        reg_write(2'd3, 8'hFF);
        reg_read(2'd3, d); check(d == 8'h01, "R5 control bit0 only", d, 1);
        reg_write(2'd3, 8'h00);
        bus_slow = 1'b1; legacy_mode = 1'b0;
    endtask

    task automatic t_wide_sweep();
        int a, r; bit k, ds;
        logic [7:0] t;
        legacy_mode = 1'b0;
        for (int c = 0; c < 16; c++) begin
            t = {4'(15 - c), 4'(c)};
            reg_write(2'd0, t);
            do_access(1'b0, c[0], a, r, k, ds);
            check(a == exp_act(0, 1, t), "R1 wide active ch0", a, exp_act(0, 1, t));
            check(r == exp_rec(0, 1, t), "R2 wide recovery ch0", r, exp_rec(0, 1, t));
            check(k && ds, "R7 strobe kind and done", k, 1);
            t = {4'(c), 4'(c)};
            reg_write(2'd2, t);
            do_access(1'b1, !c[0], a, r, k, ds);
            check(a == exp_act(0, 1, t), "R1 wide active ch1", a, exp_act(0, 1, t));
            check(r == exp_rec(0, 1, t), "R2 wide recovery ch1 clamp", r, exp_rec(0, 1, t));
            check(k && ds, "R7 ch1 kind and done", k, 1);
        end
    endtask

    task automatic t_legacy_sweep();
        int a, r; bit k, ds;
        logic [7:0] t;
        legacy_mode = 1'b1;
        for (int s = 0; s < 2; s++) begin
            bus_slow = s[0];
            for (int c = 0; c < 16; c++) begin
                t = {4'(c ^ 5), 4'(c)};
                reg_write(2'd0, t);
                do_access(1'b0, 1'b0, a, r, k, ds);
                check(a == exp_act(1, s[0], t), "R3 legacy active", a, exp_act(1, s[0], t));
                check(r == exp_rec(1, s[0], t), "R4 legacy recovery", r, exp_rec(1, s[0], t));
                check(k && ds, "R7 legacy done", k, 1);
            end
        end
        reg_write(2'd0, 8'hF7);
        bus_slow = 1'b0;
        do_access(1'b0, 1'b1, a, r, k, ds);
        check(a == 2 && r == 0, "R4 zero recovery fast bus", r, 0);
        legacy_mode = 1'b0; bus_slow = 1'b1;
    endtask

    task automatic t_disable();
        int a, r; bit k, ds;
        reg_write(2'd2, 8'hEE);
        reg_write(2'd3, 8'h01);
        do_access(1'b1, 1'b0, a, r, k, ds);
        check(a == 0 && r == 0 && !ds, "R6 control disables ch1", a, 0);
        reg_write(2'd3, 8'h00);
        legacy_mode = 1'b1;
        do_access(1'b1, 1'b0, a, r, k, ds);
        check(a == 0 && r == 0 && !ds, "R6 legacy disables ch1", a, 0);
        legacy_mode = 1'b0;
        do_access(1'b1, 1'b0, a, r, k, ds);
        check(a == 3 && ds, "R6 ch1 enabled again", a, 3);
    endtask

    task automatic t_holdoff();
        int a;
        bit bad = 1'b0;
        bit ds = 1'b0;
        reg_write(2'd0, 8'hAE);
        @(negedge clk);
        acc_req = 1'b1; acc_chan = 1'b0; acc_wr = 1'b0;
        @(negedge clk);
        acc_wr = 1'b1;
        for (int i = 0; i < 40 && !ds; i++) begin
            if (done) ds = 1'b1;
            else begin
                if (wr_strobe) bad = 1'b1;
                @(negedge clk);
            end
        end
        check(ds && !bad, "R8 held request gives no strobe", bad, 0);
        @(negedge clk);
        check(wr_strobe && busy, "R8 strobe right after done", wr_strobe, 1);
        acc_req = 1'b0;
        a = 0;
        while (wr_strobe && a < 40) begin
            a++;
            @(negedge clk);
        end
        check(a == 3, "R8 held access length", a, 3);
        while (!done) @(negedge clk);
    endtask

    task automatic t_midwrite();
        int a = 0;
        int r = 0;
        int a2, r2;
        bit k, ds;
        bit fin = 1'b0;
        reg_write(2'd0, 8'h00);
        @(negedge clk);
        acc_req = 1'b1; acc_chan = 1'b0; acc_wr = 1'b0;
        @(negedge clk);
        acc_req = 1'b0;
        for (int i = 0; i < 60 && !fin; i++) begin
            if (i == 2) begin reg_addr = 2'd0; reg_wdata = 8'hEF; reg_wr = 1'b1; end
            if (i == 3) reg_wr = 1'b0;
            if (done) fin = 1'b1;
            else if (rd_strobe) a++;
            else if (busy) r++;
            if (!fin) @(negedge clk);
        end
        check(a == 17, "R9 running access keeps active", a, 17);
        check(r == 15, "R9 running access keeps recovery", r, 15);
        do_access(1'b0, 1'b0, a2, r2, k, ds);
        check(a2 == 2, "R9 next access uses new active", a2, 2);
        check(r2 == 2, "R9 next access new recovery clamp R2", r2, 2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_wide_sweep();
        t_legacy_sweep();
        t_disable();
        t_holdoff();
        t_midwrite();
        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule